// File: doc/BRIEF.md
# Four-Bit Three-Register Instruction Datapath

This block is a small clocked processing unit built around three 4-bit working registers (A, B and C), a greater-than flag and a carry flag. On every rising clock edge it takes a 3-bit opcode and a 4-bit data field. A combinational decoder turns the opcode into a clear, per-register load enables and multiplexer selects. Those signals steer an adder, a logical left shifter, a bitwise AND unit and an unsigned magnitude comparator into the registers.

Register B loads either from the data field or from register C. Register C loads from one of three results: the sum, the shifted value or the AND. The shift amount comes from the two most significant data bits. All values are unsigned. The registers and flags drive the outputs directly, so any result can be seen one cycle after its opcode.

Top module: `tri_reg_alu`

## Requirements
- R1: An active-high `rst` clears A, B, C, `gt_flag` and `carry_flag` to 0 at once, without waiting for a clock edge.
- R2: Opcode 3'b000 sets A, B and C to 0000 at the next rising edge and leaves both flags unchanged.
- R3: Opcode 3'b001 loads A with `din` and leaves B, C and both flags unchanged.
- R4: Opcode 3'b010 loads B with `din` and leaves A, C and both flags unchanged.
- R5: Opcode 3'b011 loads B with the value C held before the edge, and leaves A, C and both flags unchanged.
- R6: Opcode 3'b100 loads C with (A + B) mod 16 and loads `carry_flag` with the carry out of the 4-bit add (1 when A + B > 15).
- R7: Opcode 3'b101 loads C with B shifted left logically by `din[3:2]` (0 to 3 places). Vacated low bits are filled with 0 and bits pushed past bit 3 are dropped.
- R8: Opcode 3'b110 sets `gt_flag` to 1 when A > B (unsigned) and to 0 otherwise, and leaves A, B and C unchanged.
- R9: Opcode 3'b111 loads C with the bitwise AND of A and B.
- R10: `gt_flag` changes only on opcode 3'b110, and `carry_flag` changes only on opcode 3'b100.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Asynchronous active-high reset |
| op | input | 3 | Opcode |
| din | input | 4 | Data field; bits 3:2 also set the shift amount |
| out_a | output | 4 | Register A |
| out_b | output | 4 | Register B |
| out_c | output | 4 | Register C |
| gt_flag | output | 1 | Set when A > B at the last compare |
| carry_flag | output | 1 | Carry out of the last add |

## Verification
The assertions check every opcode on every cycle by comparing each register and flag with its value before the edge. This covers the clear, both loads, the copy from C to B, the sum with its carry, the shift, the compare, the AND, and the rule that flags hold outside their own opcode. The asynchronous reset cannot be shown by a clocked property. Only the bench scenarios show it, because they raise reset between edges and read the outputs before the next edge. The bench scenarios also drive chosen corner values: a sum of exactly 16, every shift amount on a pattern with set bits at both ends, and equal operands at compare.

// File: rtl/tri_reg_alu.sv
module tri_reg_alu #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [2:0]   op,
  input  logic [W-1:0] din,
  output logic [W-1:0] out_a,
  output logic [W-1:0] out_b,
  output logic [W-1:0] out_c,
  output logic         gt_flag,
  output logic         carry_flag
);
  localparam int SHW = 2;

  typedef enum logic [2:0] {
    OP_CLR  = 3'b000,
    OP_LDA  = 3'b001,
    OP_LDB  = 3'b010,
    OP_CPY  = 3'b011,
    OP_ADD  = 3'b100,
    OP_SHL  = 3'b101,
    OP_CMP  = 3'b110,
    OP_AND  = 3'b111
  } opc_t;

  typedef enum logic [1:0] {
    CS_SUM = 2'b00,
    CS_SHL = 2'b01,
    CS_AND = 2'b11
  } csel_t;

  logic         clr, en_a, en_b, en_c, b_sel, cmp_en, add_en;
  csel_t        c_sel;
  logic [W-1:0] ra, rb, rc;
  logic [W-1:0] b_next, c_next, shl;
  logic [W:0]   sum;
  logic [SHW-1:0] shamt;

  always_comb begin
    clr = 1'b0; en_a = 1'b0; en_b = 1'b0; en_c = 1'b0;
    b_sel = 1'b0; cmp_en = 1'b0; add_en = 1'b0; c_sel = CS_SUM;
    case (opc_t'(op))
      OP_CLR: clr = 1'b1;
      OP_LDA: en_a = 1'b1;
      OP_LDB: en_b = 1'b1;
      OP_CPY: begin en_b = 1'b1; b_sel = 1'b1; end
      OP_ADD: begin en_c = 1'b1; add_en = 1'b1; c_sel = CS_SUM; end
      OP_SHL: begin en_c = 1'b1; c_sel = CS_SHL; end
      OP_CMP: cmp_en = 1'b1;
      OP_AND: begin en_c = 1'b1; c_sel = CS_AND; end
      default: ;
    endcase
  end

  assign b_next = b_sel ? rc : din;
  assign sum    = {1'b0, ra} + {1'b0, rb};
  assign shamt  = din[W-1 -: SHW];
  assign shl    = rb << shamt;

  always_comb begin
    case (c_sel)
      CS_SUM:  c_next = sum[W-1:0];
      CS_SHL:  c_next = shl;
      CS_AND:  c_next = ra & rb;
      default: c_next = '0;
    endcase
  end

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      ra <= '0;
      rb <= '0;
      rc <= '0;
      gt_flag <= 1'b0;
      carry_flag <= 1'b0;
    end else begin
      if (clr) begin
        ra <= '0;
        rb <= '0;
        rc <= '0;
      end else begin
        if (en_a) ra <= din;
        if (en_b) rb <= b_next;
        if (en_c) rc <= c_next;
      end
      if (cmp_en) gt_flag <= (ra > rb);
      if (add_en) carry_flag <= sum[W];
    end
  end

  assign out_a = ra;
  assign out_b = rb;
  assign out_c = rc;
endmodule

module tri_reg_alu_chk #(
  parameter int W = 4
) (
  input logic         clk,
  input logic         rst,
  input logic [2:0]   op,
  input logic [W-1:0] din,
  input logic [W-1:0] out_a,
  input logic [W-1:0] out_b,
  input logic [W-1:0] out_c,
  input logic         gt_flag,
  input logic         carry_flag
);
  AST_CLEAR_ALL: assert property (@(posedge clk) disable iff (rst)
    op == 3'b000 |=> (out_a == '0 && out_b == '0 && out_c == '0)); // R2
  AST_CLEAR_FLAGS: assert property (@(posedge clk) disable iff (rst)
    op == 3'b000 |=> (gt_flag == $past(gt_flag) && carry_flag == $past(carry_flag))); // R2
  AST_LOAD_A: assert property (@(posedge clk) disable iff (rst)
    op == 3'b001 |=> (out_a == $past(din) && out_b == $past(out_b) && out_c == $past(out_c))); // R3
  AST_LOAD_B: assert property (@(posedge clk) disable iff (rst)
    op == 3'b010 |=> (out_b == $past(din) && out_a == $past(out_a) && out_c == $past(out_c))); // R4
  AST_COPY_C_TO_B: assert property (@(posedge clk) disable iff (rst)
    op == 3'b011 |=> (out_b == $past(out_c) && out_a == $past(out_a) && out_c == $past(out_c))); // R5
  AST_ADD_CARRY: assert property (@(posedge clk) disable iff (rst)
    op == 3'b100 |=> ({carry_flag, out_c} == {1'b0, $past(out_a)} + {1'b0, $past(out_b)})); // R6
  AST_SHIFT_LEFT: assert property (@(posedge clk) disable iff (rst)
    op == 3'b101 |=> (out_c == ($past(out_b) << $past(din[W-1 -: 2])))); // R7
  AST_COMPARE: assert property (@(posedge clk) disable iff (rst)
    op == 3'b110 |=> (gt_flag == ($past(out_a) > $past(out_b)) && out_c == $past(out_c))); // R8
  AST_AND_AB: assert property (@(posedge clk) disable iff (rst)
    op == 3'b111 |=> (out_c == ($past(out_a) & $past(out_b)))); // R9
  AST_GT_HOLD: assert property (@(posedge clk) disable iff (rst)
    op != 3'b110 |=> gt_flag == $past(gt_flag)); // R10
  AST_CARRY_HOLD: assert property (@(posedge clk) disable iff (rst)
    op != 3'b100 |=> carry_flag == $past(carry_flag)); // R10
endmodule

bind tri_reg_alu tri_reg_alu_chk #(.W(W)) u_chk (.*);

// File: tb/sim_tri_reg_alu.sv
module sim_tri_reg_alu;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [2:0] op = 3'b000;
  logic [3:0] din = 4'h0;
  logic [3:0] out_a, out_b, out_c;
  logic gt_flag, carry_flag;

  logic [3:0] ma = 0, mb = 0, mc = 0;
  logic mgt = 0, mcy = 0;
  int checks = 0, failures = 0;
  bit done = 0;

  tri_reg_alu u0 (.clk(clk), .rst(rst), .op(op), .din(din), .out_a(out_a),
    .out_b(out_b), .out_c(out_c), .gt_flag(gt_flag), .carry_flag(carry_flag));

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string tag);
    checks++;
    if ({out_a, out_b, out_c, gt_flag, carry_flag} !== {ma, mb, mc, mgt, mcy}) begin
      failures++;
      $display("FAIL %s actual a=%h b=%h c=%h gt=%b cy=%b expected a=%h b=%h c=%h gt=%b cy=%b",
        tag, out_a, out_b, out_c, gt_flag, carry_flag, ma, mb, mc, mgt, mcy);
    end
  endtask

  task automatic do_op(input logic [2:0] o, input logic [3:0] d);
    logic [4:0] s;
    @(negedge clk);
    op = o; din = d;
    @(posedge clk);
    #1;
    s = {1'b0, ma} + {1'b0, mb};
    case (o)
      3'b000: begin ma = 0; mb = 0; mc = 0; end
      3'b001: ma = d;
      3'b010: mb = d;
      3'b011: mb = mc;
      3'b100: begin mc = s[3:0]; mcy = s[4]; end
      3'b101: mc = mb << d[3:2];
      3'b110: mgt = (ma > mb);
      3'b111: mc = ma & mb;
      default: ;
    endcase
  endtask

  task automatic t_reset;
    check("R1 reset state");
    @(negedge clk); rst = 0;
    do_op(3'b001, 4'h9); do_op(3'b010, 4'h8); do_op(3'b100, 4'h0); do_op(3'b110, 4'h0);
    check("R1 pre-reset setup");
    @(negedge clk); #2; rst = 1; #1;
    ma = 0; mb = 0; mc = 0; mgt = 0; mcy = 0;
    check("R1 async reset between edges");
    @(negedge clk); rst = 0;
  endtask

  task automatic t_load;
    do_op(3'b001, 4'hA); check("R3 load A");
    do_op(3'b010, 4'h5); check("R4 load B");
    do_op(3'b001, 4'h3); check("R3 reload A keeps B");
  endtask

  task automatic t_add;
    do_op(3'b001, 4'h3); do_op(3'b010, 4'h4);
    do_op(3'b100, 4'hF); check("R6 add 3+4 no carry");
    do_op(3'b001, 4'h9); do_op(3'b010, 4'h7);
    do_op(3'b100, 4'h0); check("R6 add 9+7 carry, sum 0");
    do_op(3'b001, 4'hF); do_op(3'b010, 4'hF);
    do_op(3'b100, 4'h0); check("R6 add F+F");
  endtask

  task automatic t_copy;
    do_op(3'b001, 4'h6); do_op(3'b010, 4'h2); do_op(3'b100, 4'h0);
    do_op(3'b011, 4'hF); check("R5 copy C to B ignores din");
  endtask

  task automatic t_shift;
    do_op(3'b010, 4'hB);
    for (int k = 0; k < 4; k++) begin
      do_op(3'b101, 4'(k << 2) | 4'h3);
      check($sformatf("R7 shift by %0d", k));
    end
  endtask

  task automatic t_compare;
    do_op(3'b001, 4'h9); do_op(3'b010, 4'h4);
    do_op(3'b110, 4'h0); check("R8 compare A>B");
    do_op(3'b010, 4'h9);
    do_op(3'b110, 4'h0); check("R8 compare A==B");
    do_op(3'b001, 4'h2);
    do_op(3'b110, 4'h0); check("R8 compare A<B");
  endtask

  task automatic t_and;
    do_op(3'b001, 4'hC); do_op(3'b010, 4'hA);
    do_op(3'b111, 4'h0); check("R9 and C&A");
  endtask

  task automatic t_hold;
    do_op(3'b001, 4'hF); do_op(3'b010, 4'h1); do_op(3'b110, 4'h0);
    do_op(3'b001, 4'h8); do_op(3'b010, 4'h8); do_op(3'b100, 4'h0);
    do_op(3'b101, 4'h4); do_op(3'b111, 4'h0); do_op(3'b011, 4'h0);
    check("R10 flags hold outside own opcode");
  endtask

  task automatic t_clear;
    do_op(3'b001, 4'hE); do_op(3'b010, 4'hD); do_op(3'b100, 4'h0);
    do_op(3'b000, 4'hF); check("R2 clear keeps flags");
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    failures++;
    checks++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    #3;
    t_reset();
    t_load();
    t_add();
    t_copy();
    t_shift();
    t_compare();
    t_and();
    t_hold();
    t_clear();
    finish_run();
  end
endmodule